// File: doc/BRIEF.md
# Nibble-Stream Ethernet Frame Check Sequence Verifier

This block listens to the 4-bit receive side of a 100 Mbit/s media-independent interface. It runs on the receive clock from the PHY, which is 25 MHz with one nibble per clock. While receive-valid is high it looks for the end of the preamble, which is a `0x5` nibble followed directly by a `0xD` nibble. It then pairs the nibbles that follow into bytes. It sends each byte out with a one-cycle strobe. The same bytes, including the four trailing frame check bytes, go through a byte-wide CRC-32 engine.

When receive-valid drops, the block latches two 32-bit values: the frame check value it computed and the frame check value it found on the wire. Both are kept so that they can be compared side by side. It then gives a one-cycle pass or fail verdict. The verdict comes from the fixed remainder left in the CRC register once the check bytes themselves have been absorbed. It is not a comparison of the two latched words. Frames that are too short fail. So do frames that end on half a byte, and these also raise an alignment flag.

Top module: `mii_fcs_checker`

## Requirements
- R1: While reset is asserted and on the first sample after its release, `rx_byte_stb`, `crc_ok`, `crc_err` and `align_err` are 0, and `crc_calc` and `fcs_rx` are all zeros.
- R2: No byte is forwarded for nibbles up to and including the start delimiter (a `0x5` nibble immediately followed by a `0xD` nibble). A burst of valid nibbles that never contains the delimiter produces no byte strobe and no verdict.
- R3: After the delimiter, the first nibble of each pair is bits 3:0 of the byte and the second is bits 7:4. `rx_byte_stb` pulses once per completed byte, including the four check bytes, with the byte on `rx_byte`.
- R4: The CRC is the reflected IEEE 802.3 CRC-32 (polynomial 0x04C11DB7). Each byte is consumed least significant bit first. The register is preset to 0xFFFFFFFF for the first byte after the delimiter, independent of earlier frames.
- R5: At frame end, `fcs_rx` holds the last four whole bytes received. The earliest of them is in bits 31:24 and the last in bits 7:0.
- R6: At frame end, `crc_calc` holds the complemented CRC of all bytes except the last four, laid out in the same wire order as `fcs_rx`. For an undamaged frame it therefore equals `fcs_rx`.
- R7: Exactly one of `crc_ok` and `crc_err` pulses for one cycle per frame. The pulse appears in the second cycle after the first clock edge that samples `rx_dv` low. `crc_ok` requires the bit-reversed CRC register after all bytes to equal 0xC704DD7B.
- R8: `crc_calc` and `fcs_rx` change only together with a verdict pulse. Otherwise they hold their value, including across bursts that carry no delimiter.
- R9: If the frame ends with an unpaired nibble, that nibble is dropped. `align_err` pulses together with `crc_err`.
- R10: A frame with fewer than 64 bytes after the delimiter (check bytes included) gives `crc_err` even when its remainder is correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 1 | Receive data valid |
| rx_nib | input | 4 | Receive nibble |
| rx_byte | output | 8 | Assembled byte after the delimiter |
| rx_byte_stb | output | 1 | One-cycle strobe for `rx_byte` |
| crc_calc | output | 32 | Latched computed check value, wire order |
| fcs_rx | output | 32 | Latched received check bytes, wire order |
| crc_ok | output | 1 | One-cycle pass pulse |
| crc_err | output | 1 | One-cycle fail pulse |
| align_err | output | 1 | One-cycle odd-nibble pulse, with `crc_err` |

## Verification
The bench sends frames of exactly 64 bytes and of 63 bytes, each with a correct remainder. A design with an off-by-one length limit flips the verdict on one of them.

It sends a frame that ends with a spare nibble. A design that kept the nibble, or ignored it, would report a pass or miss the alignment pulse. It also damages a payload byte in one frame and a check byte in another. A design that compares the wrong pair of values, or reverses the byte order of the latched words, then gives a mismatched `crc_calc` or `fcs_rx`, or a wrong verdict.

A good frame placed after a bad one shows whether the preset is really reapplied. A burst without a delimiter checks that nothing is forwarded or latched.

// File: rtl/mii_fcs_pkg.sv
package mii_fcs_pkg;

  localparam int unsigned NIB_W     = 4;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CRC_W     = 32;
  localparam int unsigned CHK_BYTES = CRC_W / BYTE_W;

  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET    = 32'hFFFFFFFF;
  localparam logic [CRC_W-1:0] CRC_REMAINDER = 32'hC704DD7B;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
  localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HUNT = 2'd1,
    RX_DATA = 2'd2
  } rx_state_e;

  // One byte of the reflected CRC-32, least significant data bit first.
  function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] c_in,
                                                      input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] c;
    c = c_in ^ {{(CRC_W-BYTE_W){1'b0}}, d};
    for (int i = 0; i < BYTE_W; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] bit_flip(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction

endpackage

// File: rtl/mii_nib_pack.sv
module mii_nib_pack
  import mii_fcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic [NIB_W-1:0]  rx_nib,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_stb,
  output logic              first_stb,
  output logic              eof_stb,
  output logic              odd_q
);

  rx_state_e         state_q, state_d;
  logic              phase_q, phase_d;
  logic [NIB_W-1:0]  lo_q, lo_d;
  logic              prev5_q, prev5_d;
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] byte_d;
  logic              stb_d, first_d, eof_d, odd_d;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    lo_d    = lo_q;
    prev5_d = prev5_q;
    pend_d  = pend_q;
    byte_d  = byte_q;
    stb_d   = 1'b0;
    first_d = 1'b0;
    eof_d   = 1'b0;
    odd_d   = odd_q;
    if (!rx_dv) begin
      if (state_q == RX_DATA) begin
        eof_d = 1'b1;
        odd_d = phase_q;
      end
      state_d = RX_IDLE;
      phase_d = 1'b0;
      prev5_d = 1'b0;
    end else begin
      case (state_q)
        RX_IDLE, RX_HUNT: begin
          state_d = RX_HUNT;
          if (prev5_q && (rx_nib == SFD_NIB)) begin
            state_d = RX_DATA;
            phase_d = 1'b0;
            pend_d  = 1'b1;
          end
          prev5_d = (rx_nib == PRE_NIB);
        end
        RX_DATA: begin
          if (!phase_q) begin
            lo_d    = rx_nib;
            phase_d = 1'b1;
          end else begin
            byte_d  = {rx_nib, lo_q};
            stb_d   = 1'b1;
            first_d = pend_q;
            pend_d  = 1'b0;
            phase_d = 1'b0;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      phase_q   <= 1'b0;
      lo_q      <= '0;
      prev5_q   <= 1'b0;
      pend_q    <= 1'b0;
      byte_q    <= '0;
      byte_stb  <= 1'b0;
      first_stb <= 1'b0;
      eof_stb   <= 1'b0;
      odd_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      lo_q      <= lo_d;
      prev5_q   <= prev5_d;
      pend_q    <= pend_d;
      if (stb_d) byte_q <= byte_d;
      byte_stb  <= stb_d;
      first_stb <= first_d;
      eof_stb   <= eof_d;
      if (eof_d) odd_q <= odd_d;
    end
  end

endmodule

// File: rtl/mii_crc32_byte.sv
module mii_crc32_byte
  import mii_fcs_pkg::*;
#(
  parameter int unsigned HIST = CHK_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic              first_stb,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_q,
  output logic [CRC_W-1:0]  crc_lag
);

  logic [CRC_W-1:0] crc_in, crc_d;
  logic [CRC_W-1:0] hist_q [HIST];

  always_comb begin
    crc_in = first_stb ? CRC_PRESET : crc_q;
    crc_d  = crc_step_byte(crc_in, byte_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= CRC_PRESET;
    else if (byte_stb) crc_q <= crc_d;
  end

  // Register value before each of the last HIST bytes.
  for (genvar g = 0; g < HIST; g++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        hist_q[g] <= CRC_PRESET;
      else if (byte_stb) hist_q[g] <= (g == 0) ? crc_in : hist_q[(g == 0) ? 0 : g-1];
    end
  end

  assign crc_lag = hist_q[HIST-1];

endmodule

// File: rtl/mii_fcs_verdict.sv
module mii_fcs_verdict
  import mii_fcs_pkg::*;
#(
  parameter int unsigned MIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_stb,
  input  logic              first_stb,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              eof_stb,
  input  logic              odd_q,
  input  logic [CRC_W-1:0]  crc_q,
  input  logic [CRC_W-1:0]  crc_lag,
  output logic [CRC_W-1:0]  crc_calc,
  output logic [CRC_W-1:0]  fcs_rx,
  output logic              crc_ok,
  output logic              crc_err,
  output logic              align_err
);

  localparam int unsigned     CNT_W   = $clog2(MIN_BYTES + 1);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_BYTES);
  localparam logic [CNT_W-1:0] ONE_CNT = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CRC_W-1:0] sr_q, sr_d;
  logic [CRC_W-1:0] calc_wire;
  logic             good;

  for (genvar g = 0; g < CHK_BYTES; g++) begin : g_wire
    assign calc_wire[(CHK_BYTES-1-g)*BYTE_W +: BYTE_W] = ~crc_lag[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cnt_d = cnt_q;
    sr_d  = sr_q;
    if (byte_stb) begin
      sr_d = {sr_q[CRC_W-BYTE_W-1:0], byte_in};
      if (first_stb)            cnt_d = ONE_CNT;
      else if (cnt_q != MIN_CNT) cnt_d = cnt_q + ONE_CNT;
    end else if (eof_stb) begin
      cnt_d = '0;
    end
    good = (bit_flip(crc_q) == CRC_REMAINDER) && (cnt_q >= MIN_CNT) && !odd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      sr_q      <= '0;
      crc_calc  <= '0;
      fcs_rx    <= '0;
      crc_ok    <= 1'b0;
      crc_err   <= 1'b0;
      align_err <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      sr_q      <= sr_d;
      crc_ok    <= eof_stb && good;
      crc_err   <= eof_stb && !good;
      align_err <= eof_stb && odd_q;
      if (eof_stb) begin
        crc_calc <= calc_wire;
        fcs_rx   <= sr_q;
      end
    end
  end

endmodule

// File: rtl/mii_fcs_checker.sv
module mii_fcs_checker
  import mii_fcs_pkg::*;
#(
  parameter int unsigned MIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic [NIB_W-1:0]  rx_nib,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_stb,
  output logic [CRC_W-1:0]  crc_calc,
  output logic [CRC_W-1:0]  fcs_rx,
  output logic              crc_ok,
  output logic              crc_err,
  output logic              align_err
);

  logic             first_stb, eof_stb, odd_q;
  logic [CRC_W-1:0] crc_q, crc_lag;

  mii_nib_pack u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_dv    (rx_dv),
    .rx_nib   (rx_nib),
    .byte_q   (rx_byte),
    .byte_stb (rx_byte_stb),
    .first_stb(first_stb),
    .eof_stb  (eof_stb),
    .odd_q    (odd_q)
  );

  mii_crc32_byte #(.HIST(CHK_BYTES)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (rx_byte_stb),
    .first_stb(first_stb),
    .byte_in  (rx_byte),
    .crc_q    (crc_q),
    .crc_lag  (crc_lag)
  );

  mii_fcs_verdict #(.MIN_BYTES(MIN_BYTES)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .byte_stb (rx_byte_stb),
    .first_stb(first_stb),
    .byte_in  (rx_byte),
    .eof_stb  (eof_stb),
    .odd_q    (odd_q),
    .crc_q    (crc_q),
    .crc_lag  (crc_lag),
    .crc_calc (crc_calc),
    .fcs_rx   (fcs_rx),
    .crc_ok   (crc_ok),
    .crc_err  (crc_err),
    .align_err(align_err)
  );

endmodule

// File: rtl/mii_fcs_checker_sva.sv
module mii_fcs_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_dv,
  input logic        rx_byte_stb,
  input logic [31:0] crc_calc,
  input logic [31:0] fcs_rx,
  input logic        crc_ok,
  input logic        crc_err,
  input logic        align_err
);

  a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_ok && crc_err));

  a_r7_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
    crc_ok |=> !crc_ok);

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |=> !crc_err);

  a_r7_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok || crc_err) |-> (!$past(rx_dv, 2) && $past(rx_dv, 3)));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(crc_ok || crc_err) |-> ($stable(crc_calc) && $stable(fcs_rx)));

  a_r9_align_fails: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> crc_err);

  a_r3_byte_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_stb |-> $past(rx_dv));

endmodule

bind mii_fcs_checker mii_fcs_checker_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_dv      (rx_dv),
  .rx_byte_stb(rx_byte_stb),
  .crc_calc   (crc_calc),
  .fcs_rx     (fcs_rx),
  .crc_ok     (crc_ok),
  .crc_err    (crc_err),
  .align_err  (align_err)
);

// File: tb/mii_fcs_checker_test.sv
module mii_fcs_checker_test;

  logic        clk;
  logic        rst_n;
  logic        rx_dv;
  logic [3:0]  rx_nib;
  logic [7:0]  rx_byte;
  logic        rx_byte_stb;
  logic [31:0] crc_calc, fcs_rx;
  logic        crc_ok, crc_err, align_err;

  int checks = 0;
  int errors = 0;

  mii_fcs_checker uut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib),
    .rx_byte(rx_byte), .rx_byte_stb(rx_byte_stb),
    .crc_calc(crc_calc), .fcs_rx(fcs_rx),
    .crc_ok(crc_ok), .crc_err(crc_err), .align_err(align_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {payload length, seed, mode (0 good, 1 bad payload, 2 bad check byte, 3 odd nibble), expect ok}
  localparam logic [31:0] VEC [0:6] = '{
    {8'd60,  8'd3,  8'd0, 8'd1},
    {8'd100, 8'd11, 8'd0, 8'd1},
    {8'd60,  8'd5,  8'd1, 8'd0},
    {8'd59,  8'd9,  8'd0, 8'd0},
    {8'd80,  8'd17, 8'd3, 8'd0},
    {8'd64,  8'd23, 8'd2, 8'd0},
    {8'd70,  8'd41, 8'd0, 8'd1}
  };

  logic [7:0] frm [0:255];
  logic [7:0] cap [0:255];
  int         nfrm;
  int         ncap;

  always @(negedge clk) begin
    if (rst_n && rx_byte_stb) begin
      if (ncap < 256) cap[ncap] = rx_byte;
      ncap = ncap + 1;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic check(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Bit-serial model in the unreflected orientation.
  function automatic logic [31:0] model_fcs(input int n);
    logic [31:0] c;
    logic        fb;
    logic [31:0] r;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ frm[i][b];
        c  = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
      end
    end
    for (int k = 0; k < 32; k++) r[k] = ~c[31-k];
    return {r[7:0], r[15:8], r[23:16], r[31:24]};
  endfunction

  task automatic send_nib(input logic [3:0] v);
    rx_dv  = 1'b1;
    rx_nib = v;
    @(negedge clk);
  endtask

  task automatic send_frame(input bit odd);
    ncap = 0;
    for (int i = 0; i < 15; i++) send_nib(4'h5);
    send_nib(4'hD);
    for (int i = 0; i < nfrm; i++) begin
      send_nib(frm[i][3:0]);
      send_nib(frm[i][7:4]);
    end
    if (odd) send_nib(4'hA);
    rx_dv  = 1'b0;
    rx_nib = 4'h0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual %h expected %h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    rx_dv  = 1'b0;
    rx_nib = 4'h0;
    ncap   = 0;
    repeat (3) @(negedge clk);
    check(!rx_byte_stb && !crc_ok && !crc_err && !align_err, "R1", "strobes in reset",
          {28'd0, rx_byte_stb, crc_ok, crc_err, align_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(crc_calc == 32'd0, "R1", "crc_calc after reset", crc_calc, 32'd0);
    check(fcs_rx == 32'd0, "R1", "fcs_rx after reset", fcs_rx, 32'd0);
    check(!crc_ok && !crc_err && !align_err, "R1", "verdict after reset",
          {29'd0, crc_ok, crc_err, align_err}, 32'd0);

    for (int v = 0; v < 7; v++) begin
      int          plen;
      logic [7:0]  seed;
      logic [7:0]  mode;
      bit          exp_ok;
      logic [31:0] fcs, exp_calc, exp_seen;
      plen   = int'(VEC[v][31:24]);
      seed   = VEC[v][23:16];
      mode   = VEC[v][15:8];
      exp_ok = VEC[v][0];
      for (int i = 0; i < plen; i++) frm[i] = 8'(int'(seed) + i * 37 + (i >> 3));
      nfrm = plen;
      fcs  = model_fcs(plen);
      for (int k = 0; k < 4; k++) frm[plen + k] = fcs[31 - 8*k -: 8];
      nfrm = plen + 4;
      if (mode == 8'd1) frm[10] = frm[10] ^ 8'h01;
      if (mode == 8'd2) frm[nfrm-1] = frm[nfrm-1] ^ 8'h80;
      exp_calc = model_fcs(plen);
      exp_seen = {frm[nfrm-4], frm[nfrm-3], frm[nfrm-2], frm[nfrm-1]};

      send_frame(mode == 8'd3);
      @(negedge clk);
      check(!crc_ok && !crc_err, "R7", $sformatf("row %0d early verdict", v),
            {30'd0, crc_ok, crc_err}, 32'd0);
      @(negedge clk);
      check(crc_ok == exp_ok && crc_err == !exp_ok,
            (mode == 8'd3) ? "R9" : ((plen + 4 < 64) ? "R10" : "R7"),
            $sformatf("row %0d verdict", v), {30'd0, crc_ok, crc_err}, {30'd0, exp_ok, !exp_ok});
      check(align_err == (mode == 8'd3), "R9", $sformatf("row %0d align", v),
            {31'd0, align_err}, {31'd0, mode == 8'd3});
      check(fcs_rx == exp_seen, "R5", $sformatf("row %0d fcs_rx", v), fcs_rx, exp_seen);
      check(crc_calc == exp_calc, "R6", $sformatf("row %0d crc_calc", v), crc_calc, exp_calc);
      check(ncap == nfrm, "R3", $sformatf("row %0d byte count", v), ncap, nfrm);
      begin
        int bad;
        bad = 0;
        for (int i = 0; i < nfrm && i < ncap; i++) if (cap[i] !== frm[i]) bad++;
        check(bad == 0, "R3", $sformatf("row %0d byte values", v), bad, 0);
      end
      @(negedge clk);
      check(!crc_ok && !crc_err && !align_err, "R7", $sformatf("row %0d pulse width", v),
            {29'd0, crc_ok, crc_err, align_err}, 32'd0);
      repeat (3) @(negedge clk);
    end

    // Good frame right after a bad one: preset must be reapplied (R4).
    begin
      logic [31:0] f;
      for (int i = 0; i < 64; i++) frm[i] = 8'(i * 5 + 1);
      f = model_fcs(64);
      for (int k = 0; k < 4; k++) frm[64 + k] = f[31 - 8*k -: 8];
      nfrm = 64;
      send_frame(1'b0);
      repeat (2) @(negedge clk);
      check(crc_err, "R4", "bad frame before preset test", {31'd0, crc_err}, 32'd1);
      repeat (3) @(negedge clk);
      nfrm = 68;
      send_frame(1'b0);
      repeat (2) @(negedge clk);
      check(crc_ok, "R4", "good frame after bad", {31'd0, crc_ok}, 32'd1);
      check(crc_calc == f, "R4", "calc after bad frame", crc_calc, f);
      repeat (3) @(negedge clk);
    end

    // Burst without a delimiter: nothing forwarded, nothing latched (R2, R8).
    begin
      logic [31:0] hold_seen, hold_calc;
      bit          saw_pulse;
      hold_seen = fcs_rx;
      hold_calc = crc_calc;
      saw_pulse = 0;
      ncap = 0;
      for (int i = 0; i < 12; i++) send_nib(4'h5);
      send_nib(4'h3);
      send_nib(4'hD);
      for (int i = 0; i < 6; i++) send_nib(4'h7);
      rx_dv = 1'b0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (crc_ok || crc_err) saw_pulse = 1;
      end
      check(ncap == 0, "R2", "bytes from burst without delimiter", ncap, 0);
      check(!saw_pulse, "R2", "verdict from burst without delimiter", {31'd0, saw_pulse}, 32'd0);
      check(fcs_rx == hold_seen, "R8", "fcs_rx held", fcs_rx, hold_seen);
      check(crc_calc == hold_calc, "R8", "crc_calc held", crc_calc, hold_calc);
    end

    summary();
    $finish;
  end

endmodule